// File: doc/BRIEF.md
# Priority Interrupt Dispatch Controller

This block decides, on each clock, whether the pending interrupt level presented to it is accepted. When it is, the block commits, on a single edge, the processor state that the interrupt implies. Its inputs are the pending level, the current interrupt level, the 32-bit set and enable words, a per-level line mask, the status word, the program counter and a vector-base register. It holds the banked save registers, the new status word, the cause register and the next program counter.

The two kinds of level are handled differently. A level above 1 saves the program counter and status word into that level's own bank, raises the status level field to the taken level and branches to that level's vector. Level 1 becomes a general exception. The cause register receives the level-1 code, and the status bits select a user, kernel or double exception vector. A double exception saves the program counter into a dedicated register when one is configured. Every vector can be relocated by a run-time base register.

Top module: `irq_dispatch`

## Requirements
- R1: A pending level is taken only when it is strictly greater than the current level and the AND of that level's mask word, the set word and the enable word is nonzero.
- R2: A pending level of 0, or one above the configured level count NLEVEL, is never taken and changes no output.
- R3: Taking level L>1 stores the program counter in save slot L-1 of `epc_o` and the status word in slot L-1 of `eps_o`. Slot 0 of `eps_o` is never written.
- R4: Taking level L>1 replaces status bits [3:0] with L, sets status bit 4 (exception mode) and keeps every other status bit. Taking level 1 only sets bit 4.
- R5: Taking level L>1 sets `pc_o` to the level-L vector, which is base + LVL2_OFS + (L-2)*LVL_STRIDE.
- R6: Taking level 1 writes cause code 4 into `exccause_o`. Taking a higher level leaves `exccause_o` unchanged.
- R7: Taking level 1 with status bit 4 clear stores the program counter in slot 0 of `epc_o`. The vector is USER_OFS when status bit 5 is set and KERNEL_OFS otherwise.
- R8: Taking level 1 with status bit 4 set is a double exception and uses the DOUBLE_OFS vector. The program counter goes to `depc_o` when HAS_DEPC is 1, and to slot 0 of `epc_o` otherwise.
- R9: With RELOC=1 every vector equals its default address minus DEF_BASE plus `vecbase_i`.
- R10: `taken_o` is high for exactly the cycle after each edge on which an interrupt is taken. All state updates of a take land on that edge, and no output register changes on an edge with no take.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_level_i | input | $clog2(NLEVEL+1) | Highest pending interrupt level, 0 for none |
| cur_level_i | input | 4 | Current interrupt level |
| intset_i | input | 32 | Raised interrupt lines |
| inten_i | input | 32 | Enabled interrupt lines |
| level_mask_i | input | NLEVEL x 32 | Lines belonging to each level, slot L-1 for level L |
| ps_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| vecbase_i | input | 32 | Run-time vector base |
| epc_o | output | NLEVEL x 32 | Saved program counter per level |
| eps_o | output | NLEVEL x 32 | Saved status word per level (slot 0 unused) |
| depc_o | output | 32 | Double-exception saved program counter |
| ps_o | output | 32 | Status word after the last take |
| exccause_o | output | 6 | Exception cause |
| pc_o | output | 32 | Next program counter (vector of the last take) |
| taken_o | output | 1 | One-cycle pulse after a take |

## Verification
The assertions assume that every input is a known value at each rising edge and stays constant between edges. They also assume that the current level fits the 4-bit status level field. The stimulus meets this by driving all inputs on the falling edge, starting from reset. It chooses pending levels over the whole encodable range, including values above NLEVEL, and current levels up to NLEVEL, so that the range and comparison checks see both outcomes. The status words are random, so every mix of the exception-mode and user-mode bits reaches the level-1 path.

// File: rtl/idc_pkg.sv
package idc_pkg;
  localparam int PS_LVL_W    = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;
  localparam int CAUSE_W     = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_LVL1 = 6'd4;

  typedef enum logic [1:0] {
    VK_LEVEL  = 2'd0,
    VK_USER   = 2'd1,
    VK_KERNEL = 2'd2,
    VK_DOUBLE = 2'd3
  } vec_kind_e;
endpackage

// File: rtl/idc_take.sv
module idc_take #(
  parameter int NLEVEL = 7,
  localparam int LW = $clog2(NLEVEL + 1)
) (
  input  logic [LW-1:0]             pend_i,
  input  logic [3:0]                cur_i,
  input  logic [31:0]               intset_i,
  input  logic [31:0]               inten_i,
  input  logic [NLEVEL-1:0][31:0]   mask_i,
  output logic                      take_o
);
  logic [31:0] lvl_mask;
  logic        in_range;

  always_comb begin
    lvl_mask = '0;
    in_range = (pend_i != '0) && (int'(pend_i) <= NLEVEL);
    for (int l = 1; l <= NLEVEL; l++) begin
      if (int'(pend_i) == l) lvl_mask = mask_i[l-1];
    end
  end

  assign take_o = in_range && (int'(pend_i) > int'(cur_i)) &&
                  ((lvl_mask & intset_i & inten_i) != '0);
endmodule

// File: rtl/idc_vector.sv
module idc_vector
  import idc_pkg::*;
#(
  parameter int          NLEVEL     = 7,
  parameter bit          RELOC      = 1'b1,
  parameter logic [31:0] DEF_BASE   = 32'h4000_0000,
  parameter logic [31:0] LVL2_OFS   = 32'h0000_0180,
  parameter logic [31:0] LVL_STRIDE = 32'h0000_0040,
  parameter logic [31:0] KERNEL_OFS = 32'h0000_0300,
  parameter logic [31:0] USER_OFS   = 32'h0000_0340,
  parameter logic [31:0] DOUBLE_OFS = 32'h0000_03C0,
  localparam int LW = $clog2(NLEVEL + 1)
) (
  input  logic [LW-1:0] level_i,
  input  vec_kind_e     kind_i,
  input  logic [31:0]   vecbase_i,
  output logic [31:0]   vec_o
);
  logic [31:0] def_vec;

  always_comb begin
    unique case (kind_i)
      VK_USER:   def_vec = DEF_BASE + USER_OFS;
      VK_KERNEL: def_vec = DEF_BASE + KERNEL_OFS;
      VK_DOUBLE: def_vec = DEF_BASE + DOUBLE_OFS;
      default:   def_vec = DEF_BASE + LVL2_OFS + (32'(level_i) - 32'd2) * LVL_STRIDE;
    endcase
  end

  generate
    if (RELOC) begin : g_reloc
      assign vec_o = def_vec - DEF_BASE + vecbase_i;
    end else begin : g_fixed
      logic [31:0] unused_base;
      assign unused_base = vecbase_i;
      assign vec_o = def_vec;
    end
  endgenerate
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import idc_pkg::*;
#(
  parameter int          NLEVEL     = 7,
  parameter bit          HAS_DEPC   = 1'b1,
  parameter bit          RELOC      = 1'b1,
  parameter logic [31:0] DEF_BASE   = 32'h4000_0000,
  parameter logic [31:0] LVL2_OFS   = 32'h0000_0180,
  parameter logic [31:0] LVL_STRIDE = 32'h0000_0040,
  parameter logic [31:0] KERNEL_OFS = 32'h0000_0300,
  parameter logic [31:0] USER_OFS   = 32'h0000_0340,
  parameter logic [31:0] DOUBLE_OFS = 32'h0000_03C0,
  localparam int LW = $clog2(NLEVEL + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LW-1:0]           pend_level_i,
  input  logic [3:0]              cur_level_i,
  input  logic [31:0]             intset_i,
  input  logic [31:0]             inten_i,
  input  logic [NLEVEL-1:0][31:0] level_mask_i,
  input  logic [31:0]             ps_i,
  input  logic [31:0]             pc_i,
  input  logic [31:0]             vecbase_i,
  output logic [NLEVEL-1:0][31:0] epc_o,
  output logic [NLEVEL-1:0][31:0] eps_o,
  output logic [31:0]             depc_o,
  output logic [31:0]             ps_o,
  output logic [CAUSE_W-1:0]      exccause_o,
  output logic [31:0]             pc_o,
  output logic                    taken_o
);
  localparam logic [31:0] EXCM_MASK = 32'd1 << PS_EXCM_BIT;

  logic                take;
  logic                is_l1, excm, um;
  vec_kind_e           kind;
  logic [31:0]         vec;
  logic [31:0]         ps_nxt;
  logic [PS_LVL_W-1:0] pend_ext;

  logic [31:0]         epc_q [NLEVEL];
  logic [31:0]         eps_q [NLEVEL];
  logic [31:0]         ps_q, pc_q;
  logic [CAUSE_W-1:0]  cause_q;
  logic                taken_q;

  idc_take #(.NLEVEL(NLEVEL)) u_take (
    .pend_i   (pend_level_i),
    .cur_i    (cur_level_i),
    .intset_i (intset_i),
    .inten_i  (inten_i),
    .mask_i   (level_mask_i),
    .take_o   (take)
  );

  idc_vector #(
    .NLEVEL(NLEVEL), .RELOC(RELOC), .DEF_BASE(DEF_BASE), .LVL2_OFS(LVL2_OFS),
    .LVL_STRIDE(LVL_STRIDE), .KERNEL_OFS(KERNEL_OFS), .USER_OFS(USER_OFS),
    .DOUBLE_OFS(DOUBLE_OFS)
  ) u_vec (
    .level_i   (pend_level_i),
    .kind_i    (kind),
    .vecbase_i (vecbase_i),
    .vec_o     (vec)
  );

  assign pend_ext = PS_LVL_W'(pend_level_i);
  assign excm     = ps_i[PS_EXCM_BIT];
  assign um       = ps_i[PS_UM_BIT];
  assign is_l1    = (pend_level_i == LW'(1));

  always_comb begin
    if (!is_l1)    kind = VK_LEVEL;
    else if (excm) kind = VK_DOUBLE;
    else if (um)   kind = VK_USER;
    else           kind = VK_KERNEL;
    // level 1 keeps the level field; higher levels raise it
    if (is_l1) ps_nxt = ps_i | EXCM_MASK;
    else       ps_nxt = {ps_i[31:PS_LVL_W], pend_ext} | EXCM_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < NLEVEL; l++) begin
        epc_q[l] <= '0;
        eps_q[l] <= '0;
      end
      ps_q    <= '0;
      pc_q    <= '0;
      cause_q <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= take;
      if (take) begin
        ps_q <= ps_nxt;
        pc_q <= vec;
        if (is_l1) begin
          cause_q <= CAUSE_LVL1;
          if (!(excm && HAS_DEPC)) epc_q[0] <= pc_i;
        end else begin
          for (int l = 2; l <= NLEVEL; l++) begin
            if (int'(pend_level_i) == l) begin
              epc_q[l-1] <= pc_i;
              eps_q[l-1] <= ps_i;
            end
          end
        end
      end
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      logic [31:0] depc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  depc_q <= '0;
        else if (take && is_l1 && excm) depc_q <= pc_i;
      end
      assign depc_o = depc_q;
    end else begin : g_no_depc
      assign depc_o = '0;
    end
    for (genvar g = 0; g < NLEVEL; g++) begin : g_out
      assign epc_o[g] = epc_q[g];
      assign eps_o[g] = eps_q[g];
    end
  endgenerate

  assign ps_o       = ps_q;
  assign pc_o       = pc_q;
  assign exccause_o = cause_q;
  assign taken_o    = taken_q;

  p_above_cur_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |-> ($past(pend_ext) > $past(cur_level_i)));

  p_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |-> ($past(pend_ext) != '0 && $past(pend_ext) <= PS_LVL_W'(NLEVEL)));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> ($stable(ps_o) && $stable(pc_o) && $stable(exccause_o) && $stable(depc_o)));

  p_excm_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |-> ps_o[PS_EXCM_BIT]);

  p_level_field_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !is_l1) |=> (ps_o[PS_LVL_W-1:0] == $past(pend_ext)));

  p_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && is_l1) |=> (exccause_o == CAUSE_LVL1));

  p_cause_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !is_l1) |=> $stable(exccause_o));
endmodule

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
  localparam int          NL    = 5;
  localparam int          LW    = $clog2(NL + 1);
  localparam logic [31:0] DEFB  = 32'h4000_0000;
  localparam logic [31:0] O_L2  = 32'h180;
  localparam logic [31:0] O_STR = 32'h40;
  localparam logic [31:0] O_KER = 32'h300;
  localparam logic [31:0] O_USR = 32'h340;
  localparam logic [31:0] O_DBL = 32'h3C0;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [LW-1:0]       pend = '0;
  logic [3:0]          cur = '0;
  logic [31:0]         intset = '0, inten = '0, ps = '0, pc = '0, vb = DEFB;
  logic [NL-1:0][31:0] mask = '0;

  logic [NL-1:0][31:0] epc, eps, epc_n, eps_n;
  logic [31:0]         depc, ps_o, pc_o, depc_n, ps_n, pc_n;
  logic [5:0]          cause, cause_n;
  logic                taken, taken_n;

  irq_dispatch #(.NLEVEL(NL), .HAS_DEPC(1'b1), .RELOC(1'b1), .DEF_BASE(DEFB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_level_i(pend), .cur_level_i(cur),
    .intset_i(intset), .inten_i(inten), .level_mask_i(mask), .ps_i(ps), .pc_i(pc),
    .vecbase_i(vb), .epc_o(epc), .eps_o(eps), .depc_o(depc), .ps_o(ps_o),
    .exccause_o(cause), .pc_o(pc_o), .taken_o(taken));

  irq_dispatch #(.NLEVEL(NL), .HAS_DEPC(1'b0), .RELOC(1'b1), .DEF_BASE(DEFB)) u_dut_nd (
    .clk_i(clk), .rst_ni(rst_n), .pend_level_i(pend), .cur_level_i(cur),
    .intset_i(intset), .inten_i(inten), .level_mask_i(mask), .ps_i(ps), .pc_i(pc),
    .vecbase_i(vb), .epc_o(epc_n), .eps_o(eps_n), .depc_o(depc_n), .ps_o(ps_n),
    .exccause_o(cause_n), .pc_o(pc_n), .taken_o(taken_n));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [31:0] m_epc [1:NL];
  logic [31:0] m_eps [1:NL];
  logic [31:0] m_depc, m_epc1_nd, m_ps, m_pc;
  logic [5:0]  m_cause;
  bit          m_taken;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 1; l <= NL; l++) begin m_epc[l] = 0; m_eps[l] = 0; end
      m_depc = 0; m_epc1_nd = 0; m_ps = 0; m_pc = 0; m_cause = 0; m_taken = 0;
    end else begin
      int p, c;
      bit hit;
      p = pend; c = cur;
      hit = (p >= 1) && (p <= NL) && (p > c) && ((mask[(p >= 1 && p <= NL) ? p-1 : 0] & intset & inten) != 0);
      m_taken = hit;
      if (hit) begin
        if (p == 1) begin
          m_cause = 6'd4;
          if (ps[4]) begin
            m_depc = pc; m_epc1_nd = pc; m_pc = vb + O_DBL;
          end else begin
            m_epc[1] = pc; m_epc1_nd = pc;
            m_pc = vb + (ps[5] ? O_USR : O_KER);
          end
          m_ps = ps | 32'h10;
        end else begin
          m_epc[p] = pc; m_eps[p] = ps;
          m_ps = (ps & ~32'hF) | 32'(p) | 32'h10;
          m_pc = vb + O_L2 + 32'(p - 2) * O_STR;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(taken == m_taken, "R10 taken", 32'(taken), 32'(m_taken));
    chk(ps_o == m_ps, "R4 status", ps_o, m_ps);
    chk(pc_o == m_pc, "R5 R7 R8 R9 vector", pc_o, m_pc);
    chk(cause == m_cause, "R6 cause", 32'(cause), 32'(m_cause));
    chk(depc == m_depc, "R8 depc", depc, m_depc);
    chk(epc_n[0] == m_epc1_nd, "R8 nodepc epc1", epc_n[0], m_epc1_nd);
    chk(depc_n == 0, "R8 nodepc depc", depc_n, 0);
    chk(eps[0] == 0, "R3 eps slot0", eps[0], 0);
    for (int l = 1; l <= NL; l++) begin
      chk(epc[l-1] == m_epc[l], "R3 R7 epc", epc[l-1], m_epc[l]);
      if (l > 1) chk(eps[l-1] == m_eps[l], "R3 eps", eps[l-1], m_eps[l]);
    end
  end

  task automatic step(int p, int c, logic [31:0] s, logic [31:0] e, logic [31:0] st,
                      logic [31:0] pcv, logic [31:0] vbv);
    pend = LW'(p); cur = 4'(c); intset = s; inten = e; ps = st; pc = pcv; vb = vbv;
    @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int l = 0; l < NL; l++) mask[l] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk(ps_o == 0 && pc_o == 0 && taken == 0 && cause == 0, "R11 reset", ps_o | pc_o, 0);
    rst_n = 1;
    @(negedge clk);
    // level 3, relocated base
    step(3, 1, 1, 1, 32'h20, 32'h1000, 32'h8000_0000);
    chk(taken == 1, "R10 pulse", 32'(taken), 1);
    chk(pc_o == 32'h8000_01C0, "R5 R9 level3 vec", pc_o, 32'h8000_01C0);
    chk(ps_o == 32'h33, "R4 level3 ps", ps_o, 32'h33);
    chk(epc[2] == 32'h1000 && eps[2] == 32'h20, "R3 bank3", epc[2], 32'h1000);
    chk(cause == 0, "R6 cause unchanged", 32'(cause), 0);
    step(0, 0, 1, 1, 32'h20, 32'h2000, 32'h8000_0000);
    chk(taken == 0 && pc_o == 32'h8000_01C0, "R10 no take hold", pc_o, 32'h8000_01C0);
    // level 1 user
    step(1, 0, 2, 2, 32'h20, 32'h3000, DEFB);
    chk(pc_o == DEFB + O_USR && epc[0] == 32'h3000, "R7 user", pc_o, DEFB + O_USR);
    chk(ps_o == 32'h30 && cause == 4, "R6 R4 l1 ps cause", ps_o, 32'h30);
    // level 1 kernel
    step(1, 0, 2, 2, 32'h00, 32'h3100, DEFB);
    chk(pc_o == DEFB + O_KER && epc[0] == 32'h3100, "R7 kernel", pc_o, DEFB + O_KER);
    // double
    step(1, 0, 2, 2, 32'h10, 32'h3200, DEFB);
    chk(pc_o == DEFB + O_DBL && depc == 32'h3200, "R8 double depc", depc, 32'h3200);
    chk(epc[0] == 32'h3100, "R8 epc1 kept", epc[0], 32'h3100);
    chk(epc_n[0] == 32'h3200, "R8 no-depc epc1", epc_n[0], 32'h3200);
    // rejections
    step(6, 0, 1, 1, 32'h0, 32'h4000, DEFB);
    chk(taken == 0 && pc_o == DEFB + O_DBL, "R2 above NLEVEL", pc_o, DEFB + O_DBL);
    step(2, 2, 1, 1, 32'h0, 32'h4100, DEFB);
    chk(taken == 0, "R1 equal level", 32'(taken), 0);
    step(4, 0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h4200, DEFB);
    chk(taken == 0 && epc[3] == 0, "R1 no line", epc[3], 0);
    mask[3] = 32'h0000_00F0;
    step(4, 0, 32'h0F, 32'h0F, 32'h0, 32'h4300, DEFB);
    chk(taken == 0, "R1 mask excludes", 32'(taken), 0);
    step(4, 0, 32'h1F, 32'h10, 32'h0, 32'h4400, DEFB);
    chk(taken == 1 && epc[3] == 32'h4400, "R1 mask hit", epc[3], 32'h4400);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      for (int l = 0; l < NL; l++) mask[l] = $urandom() & $urandom();
      step($urandom_range(0, 7), $urandom_range(0, NL), $urandom(), $urandom(),
           $urandom(), $urandom(), $urandom() & 32'hFFFF_F000);
    end
    finish_up();
  end
endmodule